// File: doc/BRIEF.md
# Retriggerable Pulse-Width Timer

This block is a 16-bit up-counting timer. One compare value sets the period and three more set the pulse widths of three outputs. Once enabled, the counter parks at its all-ones value and waits. A trigger clears it to zero and starts a pulse cycle. The trigger is either a chosen edge on an external pin or a one-shot software strobe. Each output goes high at the start of a cycle and falls when the counter reaches that channel's compare value. The counter wraps after it passes the period value, so the waveform repeats until the next trigger restarts it or the timer is disabled.

Software loads the four compare values through a small write port. The counter compares against shadow copies of them. The shadows reload only while the timer is disabled and at each counter clear, so a write during a cycle never tears the waveform in progress. A 3-bit field divides the system clock by a power of two to form the count clock.

Top module: `trig_pwm_timer`

## Requirements
- R1: After a synchronous reset, all pulse outputs and all interrupt lines are low.
- R2: While enabled but not yet triggered, the outputs stay low and no interrupt fires.
- R3: The edge mode field selects the external trigger edge: 0 = none, 1 = rising, 2 = falling, 3 = both. A qualifying pin change takes effect at the first clock edge after the change. An edge of the wrong type has no effect.
- R4: A software strobe sets a trigger bit on one clock edge. The bit clears itself on the next edge, which is the edge that starts the cycle.
- R5: The period is (CMP0 + 1) × D system clocks. Interrupt line 0 pulses for one clock each time the counter wraps at the end of a period.
- R6: Output k (k = 1..3) is high for the first CMPk × D clocks of each period. A CMPk of zero keeps it low for the whole period. A CMPk above CMP0 keeps it high for the whole period.
- R7: Interrupt line k (k = 1..3) pulses for one clock when the counter reaches a nonzero CMPk, on the same clock that output k falls.
- R8: A trigger during a running cycle clears the counter to zero and restarts the period. Every output with a nonzero compare value goes high again, whatever its level was.
- R9: A compare value written during a cycle takes effect only from the next counter clear. The cycle in progress keeps its old period and widths.
- R10: The count clock is the system clock divided by D = 2^clk_sel, with clk_sel = 0..7.
- R11: Clearing enable drives all outputs and interrupts low on the next clock. A new trigger is then needed before counting resumes.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock |
| rst | input | 1 | Synchronous active-high reset |
| enable | input | 1 | Timer run enable |
| clk_sel | input | 3 | Count-clock divider select, D = 2^clk_sel |
| edge_mode | input | 2 | External trigger edge: 0 none, 1 rising, 2 falling, 3 both |
| ext_trig | input | 1 | External trigger pin |
| sw_trig_set | input | 1 | Software trigger strobe |
| cmp_wr | input | 1 | Compare register write strobe |
| cmp_addr | input | 2 | Compare register index (0 = period, 1..3 = channels) |
| cmp_wdata | input | 16 | Compare write data |
| pwm_out | output | 3 | Pulse-width outputs, bit k-1 for channel k |
| cmp_irq | output | 4 | Compare-match interrupt pulses, bit 0 for the period |

## Verification
A counter that runs past the period value or misses its wrap shows on the next expected rising edge of the pulse outputs and on interrupt line 0, within one period of D clocks. A stale shadow value shows as a wrong falling-edge position or a missing channel interrupt in the first cycle after the clear that should have reloaded it. A trigger or enable fault shows on the very next clock, because outputs then rise or fall when they should not. For this reason the bench compares every output on every clock against values it computes from the cycle position.

// File: rtl/trig_pwm_pkg.sv
package trig_pwm_pkg;

    localparam int CNT_W  = 16;
    localparam int N_DUTY = 3;
    localparam int SEL_W  = 3;

    typedef enum logic [1:0] {
        EDGE_NONE = 2'd0,
        EDGE_RISE = 2'd1,
        EDGE_FALL = 2'd2,
        EDGE_BOTH = 2'd3
    } edge_mode_e;

    // Per-clock counter events shared by the counter and the channels
    typedef struct packed {
        logic clear;   // counter goes to zero (trigger or wrap)
        logic step;    // counter increments by one
        logic wrap;    // period end without a coincident trigger
    } cnt_evt_t;

    function automatic logic edge_hit(edge_mode_e m, logic now, logic prev);
        logic hit;
        case (m)
            EDGE_RISE: hit = now & ~prev;
            EDGE_FALL: hit = ~now & prev;
            EDGE_BOTH: hit = now ^ prev;
            default:   hit = 1'b0;
        endcase
        return hit;
    endfunction

endpackage

// File: rtl/tpt_prescaler.sv
module tpt_prescaler #(
    parameter int SEL_W = trig_pwm_pkg::SEL_W
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             clr,
    input  logic [SEL_W-1:0] sel,
    output logic             tick
);
    localparam int PRE_W = (1 << SEL_W) - 1;

    logic [PRE_W-1:0] pre;
    logic [PRE_W-1:0] mask;

    always_comb begin
        for (int b = 0; b < PRE_W; b++) begin
            mask[b] = (b < int'(sel));
        end
    end

    assign tick = ((pre & mask) == mask);

    always_ff @(posedge clk) begin
        if (rst || clr) begin
            pre <= '0;
        end else begin
            pre <= pre + 1'b1;
        end
    end

    // With no division the count clock is present on every cycle after a restart
    AST_FULL_RATE_TICK: assert property (@(posedge clk) disable iff (rst)
        (clr && sel == '0 && $stable(sel)) |=> (sel != '0 || tick)); // R10

endmodule

// File: rtl/tpt_trigger.sv
module tpt_trigger
    import trig_pwm_pkg::*;
(
    input  logic       clk,
    input  logic       rst,
    input  edge_mode_e mode,
    input  logic       ext_pin,
    input  logic       sw_set,
    output logic       trig
);
    logic pin_prev;
    logic sw_bit;

    always_ff @(posedge clk) begin
        if (rst) begin
            pin_prev <= 1'b0;
            sw_bit   <= 1'b0;
        end else begin
            pin_prev <= ext_pin;
            sw_bit   <= sw_set;
        end
    end

    assign trig = edge_hit(mode, ext_pin, pin_prev) | sw_bit;

    // A held pin with no strobe pending never triggers
    AST_NO_PHANTOM_TRIG: assert property (@(posedge clk) disable iff (rst)
        ($stable(ext_pin) && !$past(sw_set)) |-> !trig); // R3

endmodule

// File: rtl/tpt_duty_chan.sv
module tpt_duty_chan
    import trig_pwm_pkg::*;
#(
    parameter int CNT_W = trig_pwm_pkg::CNT_W
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             enable,
    input  logic [CNT_W-1:0] cmp_val,
    input  cnt_evt_t         evt,
    input  logic [CNT_W-1:0] cnt_nxt,
    output logic             out,
    output logic             irq
);
    logic [CNT_W-1:0] shadow;
    logic             hit;

    assign hit = evt.step && (cnt_nxt == shadow);

    always_ff @(posedge clk) begin
        if (rst) begin
            shadow <= '0;
            out    <= 1'b0;
            irq    <= 1'b0;
        end else begin
            if (!enable || evt.clear) begin
                shadow <= cmp_val;
            end
            if (!enable) begin
                out <= 1'b0;
            end else if (evt.clear) begin
                out <= (cmp_val != '0);
            end else if (hit) begin
                out <= 1'b0;
            end
            irq <= enable && hit;
        end
    end

    AST_CHAN_OFF_QUIET: assert property (@(posedge clk) disable iff (rst)
        !enable |=> (!out && !irq)); // R11

    AST_CHAN_IRQ_SINGLE: assert property (@(posedge clk) disable iff (rst)
        irq |=> !irq); // R7

    AST_CHAN_IRQ_WITH_FALL: assert property (@(posedge clk) disable iff (rst)
        irq |-> !out); // R7

endmodule

// File: rtl/trig_pwm_timer.sv
module trig_pwm_timer
    import trig_pwm_pkg::*;
#(
    parameter int CNT_W  = trig_pwm_pkg::CNT_W,
    parameter int N_DUTY = trig_pwm_pkg::N_DUTY,
    parameter int SEL_W  = trig_pwm_pkg::SEL_W
) (
    input  logic                         clk,
    input  logic                         rst,
    input  logic                         enable,
    input  logic [SEL_W-1:0]             clk_sel,
    input  logic [1:0]                   edge_mode,
    input  logic                         ext_trig,
    input  logic                         sw_trig_set,
    input  logic                         cmp_wr,
    input  logic [$clog2(N_DUTY+1)-1:0]  cmp_addr,
    input  logic [CNT_W-1:0]             cmp_wdata,
    output logic [N_DUTY-1:0]            pwm_out,
    output logic [N_DUTY:0]              cmp_irq
);
    localparam int N_CMP = N_DUTY + 1;
    localparam int AW    = $clog2(N_CMP);

    logic [CNT_W-1:0] cmp_reg [N_CMP];
    logic [CNT_W-1:0] per_shadow;
    logic [CNT_W-1:0] cnt;
    logic [CNT_W-1:0] cnt_nxt;
    logic             running;
    logic             irq_wrap;
    logic             trig;
    logic             tick;
    logic             at_top;
    cnt_evt_t         evt;

    // Compare register file
    for (genvar g = 0; g < N_CMP; g++) begin : g_cmp
        always_ff @(posedge clk) begin
            if (rst) begin
                cmp_reg[g] <= '0;
            end else if (cmp_wr && cmp_addr == AW'(g)) begin
                cmp_reg[g] <= cmp_wdata;
            end
        end
    end

    tpt_trigger u_trig (
        .clk     (clk),
        .rst     (rst),
        .mode    (edge_mode_e'(edge_mode)),
        .ext_pin (ext_trig),
        .sw_set  (sw_trig_set),
        .trig    (trig)
    );

    tpt_prescaler #(.SEL_W(SEL_W)) u_pre (
        .clk  (clk),
        .rst  (rst),
        .clr  (!enable || trig),
        .sel  (clk_sel),
        .tick (tick)
    );

    assign at_top    = (cnt == per_shadow);
    assign cnt_nxt   = cnt + 1'b1;
    assign evt.wrap  = enable && running && tick && at_top && !trig;
    assign evt.clear = enable && (trig || (running && tick && at_top));
    assign evt.step  = enable && running && tick && !at_top && !trig;

    always_ff @(posedge clk) begin
        if (rst) begin
            cnt        <= '1;
            running    <= 1'b0;
            per_shadow <= '0;
            irq_wrap   <= 1'b0;
        end else begin
            if (!enable || evt.clear) begin
                per_shadow <= cmp_reg[0];
            end
            if (!enable) begin
                cnt     <= '1;
                running <= 1'b0;
            end else if (evt.clear) begin
                cnt     <= '0;
                running <= 1'b1;
            end else if (evt.step) begin
                cnt     <= cnt_nxt;
            end
            irq_wrap <= evt.wrap;
        end
    end

    assign cmp_irq[0] = irq_wrap;

    for (genvar k = 1; k <= N_DUTY; k++) begin : g_chan
        tpt_duty_chan #(.CNT_W(CNT_W)) u_chan (
            .clk     (clk),
            .rst     (rst),
            .enable  (enable),
            .cmp_val (cmp_reg[k]),
            .evt     (evt),
            .cnt_nxt (cnt_nxt),
            .out     (pwm_out[k-1]),
            .irq     (cmp_irq[k])
        );
    end

    AST_OFF_PARKS: assert property (@(posedge clk) disable iff (rst)
        !enable |=> (cnt == '1 && !running)); // R11

    AST_TRIG_RESTART: assert property (@(posedge clk) disable iff (rst)
        (enable && trig) |=> (cnt == '0 && running)); // R8

    AST_CNT_IN_PERIOD: assert property (@(posedge clk) disable iff (rst)
        running |-> (cnt <= per_shadow)); // R5

    AST_WRAP_AT_ZERO: assert property (@(posedge clk) disable iff (rst)
        irq_wrap |-> (cnt == '0 && running)); // R5

    AST_IDLE_QUIET: assert property (@(posedge clk) disable iff (rst)
        (!running && $past(!running)) |-> (cmp_irq == '0)); // R2

endmodule

// File: tb/test_trig_pwm_timer.sv
`timescale 1ns/1ps
module test_trig_pwm_timer;

    logic        clk = 1'b0;
    logic        rst;
    logic        enable;
    logic [2:0]  clk_sel;
    logic [1:0]  edge_mode;
    logic        ext_trig;
    logic        sw_trig_set;
    logic        cmp_wr;
    logic [1:0]  cmp_addr;
    logic [15:0] cmp_wdata;
    logic [2:0]  pwm_out;
    logic [3:0]  cmp_irq;

    int n_tests = 0;
    int n_fail  = 0;
    int cc [4];
    int dv;

    always #2 clk = ~clk;

    trig_pwm_timer i_trig_pwm_timer (
        .clk         (clk),
        .rst         (rst),
        .enable      (enable),
        .clk_sel     (clk_sel),
        .edge_mode   (edge_mode),
        .ext_trig    (ext_trig),
        .sw_trig_set (sw_trig_set),
        .cmp_wr      (cmp_wr),
        .cmp_addr    (cmp_addr),
        .cmp_wdata   (cmp_wdata),
        .pwm_out     (pwm_out),
        .cmp_irq     (cmp_irq)
    );

    task automatic expect_state(input logic [2:0] eo, input logic [3:0] ei, input string tag);
        n_tests++;
        if (pwm_out !== eo) begin
            n_fail++;
            $display("FAIL %s pwm_out=%b expected %b at %0t", tag, pwm_out, eo, $time);
        end
        n_tests++;
        if (cmp_irq !== ei) begin
            n_fail++;
            $display("FAIL %s cmp_irq=%b expected %b at %0t", tag, cmp_irq, ei, $time);
        end
    endtask

    // Expected outputs idx clocks after a cycle start (R5, R6, R7, R10)
    task automatic model(input int idx, input bit wrapped,
                         output logic [2:0] eo, output logic [3:0] ei);
        int p;
        int ph;
        p  = (cc[0] + 1) * dv;
        ph = idx % p;
        ei[0] = (ph == 0) && (idx > 0 || wrapped);
        for (int k = 1; k < 4; k++) begin
            eo[k-1] = (ph < cc[k] * dv);
            ei[k]   = (cc[k] != 0) && (ph == cc[k] * dv);
        end
    endtask

    task automatic observe(input int n, input string tag);
        logic [2:0] eo;
        logic [3:0] ei;
        for (int i = 0; i < n; i++) begin
            model(i, 1'b0, eo, ei);
            expect_state(eo, ei, tag);
            @(negedge clk);
        end
    endtask

    task automatic write_cmp(input int a, input int v);
        cmp_wr    = 1'b1;
        cmp_addr  = 2'(a);
        cmp_wdata = 16'(v);
        @(negedge clk);
        cmp_wr    = 1'b0;
    endtask

    task automatic setup(input int a0, input int a1, input int a2, input int a3,
                         input int sel, input int mode, input logic pin);
        @(negedge clk);
        enable    = 1'b0;
        edge_mode = 2'(mode);
        ext_trig  = pin;
        clk_sel   = 3'(sel);
        write_cmp(0, a0);
        write_cmp(1, a1);
        write_cmp(2, a2);
        write_cmp(3, a3);
        cc[0] = a0; cc[1] = a1; cc[2] = a2; cc[3] = a3;
        dv = 1 << sel;
        @(negedge clk);
        enable = 1'b1;
        for (int i = 0; i < 3; i++) begin
            @(negedge clk);
            expect_state(3'b000, 4'b0000, "R2 idle before trigger");
        end
    endtask

    // src: 0 rising pin, 1 falling pin, 2 pin toggle, 3 software strobe
    task automatic fire(input int src);
        if (src == 3) begin
            sw_trig_set = 1'b1;
            @(negedge clk);
            sw_trig_set = 1'b0;
            @(negedge clk);
        end else begin
            if (src == 0)      ext_trig = 1'b1;
            else if (src == 1) ext_trig = 1'b0;
            else               ext_trig = ~ext_trig;
            @(negedge clk);
        end
    endtask

    initial begin
        repeat (150000) @(posedge clk);
        n_fail++;
        $display("FAIL watchdog R1..: run did not finish, cycles=150000 expected fewer");
        $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
        $finish;
    end

    initial begin
        int run;
        logic [2:0] eo;
        logic [3:0] ei;
        rst = 1'b1; enable = 1'b0; clk_sel = '0; edge_mode = '0; ext_trig = 1'b0;
        sw_trig_set = 1'b0; cmp_wr = 1'b0; cmp_addr = '0; cmp_wdata = '0;
        dv = 1; cc[0] = 0; cc[1] = 0; cc[2] = 0; cc[3] = 0;
        repeat (4) @(negedge clk);
        rst = 1'b0;
        @(negedge clk);
        expect_state(3'b000, 4'b0000, "R1 reset state");

        // Sweep: dividers, periods, duty values and every trigger source
        run = 0;
        for (int sel = 0; sel < 3; sel++) begin
            for (int c0 = 0; c0 < 5; c0++) begin
                for (int j = 0; j <= c0 + 1; j++) begin
                    int src;
                    int mode;
                    src  = run % 4;
                    mode = (src == 0) ? 1 : (src == 1) ? 2 : (src == 2) ? 3 : 0;
                    setup(c0, j, c0, c0 + 3, sel, mode, (src == 1));
                    fire(src);
                    observe(3 * (c0 + 1) * (1 << sel) + 2,
                            $sformatf("R5/R6/R7/R10 src%0d(R3 R4) sel=%0d c0=%0d c1=%0d",
                                      src, sel, c0, j));
                    run++;
                end
            end
        end

        // R3: edge mode none ignores pin activity
        setup(4, 2, 2, 2, 0, 0, 1'b0);
        for (int i = 0; i < 6; i++) begin
            ext_trig = ~ext_trig;
            @(negedge clk);
            expect_state(3'b000, 4'b0000, "R3 mode none ignores pin");
        end
        // R3: rising mode ignores a falling edge, then reacts to a rising one
        setup(4, 2, 1, 3, 0, 1, 1'b1);
        ext_trig = 1'b0;
        for (int i = 0; i < 6; i++) begin
            @(negedge clk);
            expect_state(3'b000, 4'b0000, "R3 rising mode ignores fall");
        end
        fire(0);
        observe(12, "R3 rising edge starts cycle");

        // R8: retrigger mid-cycle on pin toggle
        setup(9, 2, 5, 0, 0, 3, 1'b0);
        fire(2);
        observe(6, "R8 first cycle");
        fire(2);
        observe(25, "R8 restarted cycle");
        // R8 with software strobe under a divider
        setup(6, 3, 1, 8, 1, 0, 1'b0);
        fire(3);
        observe(9, "R8 sw first cycle");
        fire(3);
        // the strobe consumed one extra clock before the restart: realign
        observe(30, "R8 sw restarted cycle");

        // R9: mid-cycle writes wait for the next clear
        setup(5, 2, 4, 1, 0, 1, 1'b0);
        fire(0);
        for (int i = 0; i < 6 + 16 + 2; i++) begin
            if (i == 6) begin
                cc[0] = 7;
                cc[1] = 5;
            end
            if (i < 6) model(i, 1'b0, eo, ei);
            else       model(i - 6, 1'b1, eo, ei);
            expect_state(eo, ei, "R9 buffered compare update");
            if (i == 2) begin
                cmp_wr = 1'b1; cmp_addr = 2'd0; cmp_wdata = 16'd7;
            end else if (i == 3) begin
                cmp_addr = 2'd1; cmp_wdata = 16'd5;
            end else if (i == 4) begin
                cmp_wr = 1'b0;
            end
            @(negedge clk);
        end

        // R11: disable mid-cycle, then re-enable without a trigger
        setup(7, 3, 6, 2, 0, 1, 1'b0);
        fire(0);
        observe(2, "R11 running before disable");
        enable = 1'b0;
        @(negedge clk);
        expect_state(3'b000, 4'b0000, "R11 outputs low after disable");
        enable = 1'b1;
        for (int i = 0; i < 20; i++) begin
            @(negedge clk);
            expect_state(3'b000, 4'b0000, "R11 waits for new trigger");
        end
        fire(2 - 2);
        // pin is already high, so pull it low then raise it again
        ext_trig = 1'b0;
        @(negedge clk);
        fire(0);
        observe(16, "R11 restart after re-enable");

        $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
        $finish;
    end

endmodule